// File: doc/BRIEF.md
# Step-Indexed Trapezoidal Velocity Reference

This block supplies the speed that a stepper indexer must honour for each coming step of a point-to-point move. A start pulse captures four move parameters: floor speed, ceiling speed, per-step speed delta and the number of steps to travel. From then on the block advances only when the indexer reports that a step was taken. The speed reference is therefore a function of step number, not of elapsed time. It runs beside the indexer as an independent piece of logic.

The reference climbs from the floor by one delta per step and never goes above the ceiling. It holds at the ceiling, then falls by one delta per step once the steps left are no more than the steps spent climbing. It is back at the floor for the last step. When the ceiling cannot be reached in the distance available, the climb stops near the middle of the move and the profile becomes a triangle. After the final strobe the block raises its done flag and holds the floor speed until the next start.

Top module: `trap_vel_ref`

## Requirements
- R1: After reset, vel_o is 0 and done_o is 1.
- R2: A start_i pulse latches vmin_i, vmax_i, accel_i and steps_i. In the next cycle vel_o equals the latched floor, and done_o is 1 if steps_i is 0 and 0 otherwise. A step_i strobe in the same cycle as start_i is ignored.
- R3: A strobe raises vel_o by accel_i, clamped to vmax_i, and increments the climb count. This happens when vel_o is below vmax_i and the steps left after the strobe exceed the climb count plus one.
- R4: Once a move has started, vel_o never exceeds the larger of the latched floor and ceiling. When a raise would overshoot the ceiling, vel_o takes the ceiling value.
- R5: A strobe that leaves a non-zero number of steps left, no greater than the climb count, lowers vel_o by accel_i (never below the floor) and decrements the climb count.
- R6: If the ceiling is not reached, the climb stops near the middle of the move. The fall that follows takes as many steps as the climb, so vel_o is at the floor when one step is left.
- R7: The strobe that takes the last step sets done_o to 1 and vel_o to the floor. While done_o is 1, strobes change neither output.
- R8: Changes to vmin_i, vmax_i, accel_i or steps_i between start pulses have no effect on vel_o or done_o.
- R9: In a cycle with neither start_i nor step_i, vel_o and done_o keep their values.
- R10: If vmax_i is not above vmin_i, vel_o stays at vmin_i for the whole move.
- R11: Step counts up to 65535 are accepted, which covers a 12000-step move. Strobes may arrive in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Latch parameters and begin a move |
| step_i | input | 1 | Step-taken strobe from the indexer |
| vmin_i | input | 16 | Floor speed, steps per second |
| vmax_i | input | 16 | Ceiling speed, steps per second |
| accel_i | input | 16 | Speed change per step |
| steps_i | input | 16 | Total steps of the move |
| vel_o | output | 16 | Speed reference for the next step, unsigned steps per second |
| done_o | output | 1 | Move complete, or no move started |

## Verification
Every start or strobe shows up on vel_o and done_o one clock edge later: one register stage lies between the inputs and the outputs. A scoreboard entry is queued when the stimulus is driven on a falling edge. The monitor pops it on the next falling edge, but only if a flop in the bench saw the stimulus on the rising edge in between, so every comparison falls in the cycle the result is due. Checks that need no stimulus, such as the reset state, idle stability and the triangular peak, are read after the scoreboard has drained. That way each value read is already settled.

// File: rtl/trap_vref_pkg.sv
package trap_vref_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_END  = 2'd3
  } ramp_op_e;
endpackage

// File: rtl/trap_vref_cfg.sv
module trap_vref_cfg #(
  parameter int VEL_W  = 16,
  parameter int STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [VEL_W-1:0]  vmin_i,
  input  logic [VEL_W-1:0]  vmax_i,
  input  logic [VEL_W-1:0]  accel_i,
  output logic [VEL_W-1:0]  vmin_o,
  output logic [VEL_W-1:0]  vmax_o,
  output logic [VEL_W-1:0]  accel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vmin_o  <= '0;
      vmax_o  <= '0;
      accel_o <= '0;
    end else if (load_i) begin
      vmin_o  <= vmin_i;
      vmax_o  <= vmax_i;
      accel_o <= accel_i;
    end
  end
endmodule

// File: rtl/trap_vref_seq.sv
module trap_vref_seq
  import trap_vref_pkg::*;
#(
  parameter int STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic              below_max_i,
  output ramp_op_e          op_o,
  output logic              done_o
);
  localparam int CW = STEP_W + 1;

  logic [STEP_W-1:0] rem_q, acc_q;
  logic [STEP_W-1:0] rem_dec;
  logic [CW-1:0]     acc_inc;
  logic              adv;

  assign adv     = step_i && !done_o && !load_i;
  assign rem_dec = rem_q - STEP_W'(1);
  assign acc_inc = {1'b0, acc_q} + CW'(1);

  always_comb begin
    op_o = OP_HOLD;
    if (adv) begin
      if (rem_dec == '0)                          op_o = OP_END;
      else if (rem_dec <= acc_q)                  op_o = OP_DOWN;
      else if (below_max_i && ({1'b0, rem_dec} > acc_inc)) op_o = OP_UP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      acc_q  <= '0;
      done_o <= 1'b1;
    end else if (load_i) begin
      rem_q  <= steps_i;
      acc_q  <= '0;
      done_o <= (steps_i == '0);
    end else if (adv) begin
      rem_q <= rem_dec;
      unique case (op_o)
        OP_UP:   acc_q <= acc_inc[STEP_W-1:0];
        OP_DOWN: acc_q <= acc_q - STEP_W'(1);
        OP_END: begin
          acc_q  <= '0;
          done_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_vref_ramp.sv
module trap_vref_ramp
  import trap_vref_pkg::*;
#(
  parameter int VEL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VEL_W-1:0] load_vmin_i,
  input  logic [VEL_W-1:0] vmin_i,
  input  logic [VEL_W-1:0] vmax_i,
  input  logic [VEL_W-1:0] accel_i,
  input  ramp_op_e         op_i,
  output logic [VEL_W-1:0] vel_o,
  output logic             below_max_o
);
  localparam int SW = VEL_W + 1;

  logic [SW-1:0]    up_sum, dn_diff;
  logic [VEL_W-1:0] up_val, dn_val;

  assign below_max_o = vel_o < vmax_i;
  assign up_sum  = {1'b0, vel_o} + {1'b0, accel_i};
  assign dn_diff = {1'b0, vel_o} - {1'b0, accel_i};
  // clamp to ceiling on the way up, to floor on the way down
  assign up_val  = (up_sum > {1'b0, vmax_i}) ? vmax_i : up_sum[VEL_W-1:0];
  assign dn_val  = (dn_diff[VEL_W] || (dn_diff[VEL_W-1:0] < vmin_i)) ? vmin_i
                                                                       : dn_diff[VEL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vel_o <= '0;
    end else if (load_i) begin
      vel_o <= load_vmin_i;
    end else begin
      unique case (op_i)
        OP_UP:   vel_o <= up_val;
        OP_DOWN: vel_o <= dn_val;
        OP_END:  vel_o <= vmin_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_vel_ref.sv
module trap_vel_ref
  import trap_vref_pkg::*;
#(
  parameter int VEL_W  = 16,
  parameter int STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [VEL_W-1:0]  vmin_i,
  input  logic [VEL_W-1:0]  vmax_i,
  input  logic [VEL_W-1:0]  accel_i,
  input  logic [STEP_W-1:0] steps_i,
  output logic [VEL_W-1:0]  vel_o,
  output logic              done_o
);
  logic [VEL_W-1:0] cfg_vmin, cfg_vmax, cfg_accel;
  logic             below_max;
  ramp_op_e         op;

  trap_vref_cfg #(.VEL_W(VEL_W), .STEP_W(STEP_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .vmin_i  (vmin_i),
    .vmax_i  (vmax_i),
    .accel_i (accel_i),
    .vmin_o  (cfg_vmin),
    .vmax_o  (cfg_vmax),
    .accel_o (cfg_accel)
  );

  trap_vref_seq #(.STEP_W(STEP_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .step_i      (step_i),
    .steps_i     (steps_i),
    .below_max_i (below_max),
    .op_o        (op),
    .done_o      (done_o)
  );

  trap_vref_ramp #(.VEL_W(VEL_W)) u_ramp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .load_vmin_i (vmin_i),
    .vmin_i      (cfg_vmin),
    .vmax_i      (cfg_vmax),
    .accel_i     (cfg_accel),
    .op_i        (op),
    .vel_o       (vel_o),
    .below_max_o (below_max)
  );
endmodule

// File: rtl/trap_vel_ref_chk.sv
module trap_vel_ref_chk #(
  parameter int VEL_W  = 16,
  parameter int STEP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              step_i,
  input logic [VEL_W-1:0]  vmin_i,
  input logic [VEL_W-1:0]  vmax_i,
  input logic [VEL_W-1:0]  accel_i,
  input logic [STEP_W-1:0] steps_i,
  input logic [VEL_W-1:0]  vel_o,
  input logic              done_o
);
  localparam int SW = VEL_W + 1;

  logic             armed;
  logic [VEL_W-1:0] lo_l, hi_l, d_l;
  logic [VEL_W-1:0] cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed <= 1'b0;
      lo_l  <= '0;
      hi_l  <= '0;
      d_l   <= '0;
    end else if (start_i) begin
      armed <= 1'b1;
      lo_l  <= vmin_i;
      hi_l  <= vmax_i;
      d_l   <= accel_i;
    end
  end

  assign cap = (hi_l > lo_l) ? hi_l : lo_l;

  a_r2_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (vel_o == $past(vmin_i)) && (done_o == ($past(steps_i) == '0)));

  a_r3_step_delta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && step_i && !start_i) |=>
      ({1'b0, vel_o} <= {1'b0, $past(vel_o)} + SW'(d_l)) &&
      ({1'b0, $past(vel_o)} <= {1'b0, vel_o} + SW'(d_l)));

  a_r4_below_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !start_i) |-> vel_o <= cap);

  a_r5_above_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> vel_o >= lo_l);

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r7_done_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && done_o && !start_i) |-> vel_o == lo_l);

  a_r9_quiet_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !step_i) |=> $stable(vel_o) && $stable(done_o));
endmodule

bind trap_vel_ref trap_vel_ref_chk #(.VEL_W(VEL_W), .STEP_W(STEP_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .step_i  (step_i),
  .vmin_i  (vmin_i),
  .vmax_i  (vmax_i),
  .accel_i (accel_i),
  .steps_i (steps_i),
  .vel_o   (vel_o),
  .done_o  (done_o)
);

// File: tb/trap_vel_ref_test.sv
module trap_vel_ref_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, step;
  logic [15:0] vmin, vmax, accel, steps;
  logic [15:0] vel;
  logic        done;

  always #5 clk = ~clk;

  trap_vel_ref uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step),
    .vmin_i(vmin), .vmax_i(vmax), .accel_i(accel), .steps_i(steps),
    .vel_o(vel), .done_o(done)
  );

  typedef struct {int v; int d; string tag;} exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  int m_vel = 0, m_rem = 0, m_acc = 0, m_done = 1, m_lo = 0, m_hi = 0, m_d = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model built from R3, R5, R7
  task automatic model_step();
    int r;
    if (m_done != 0) return;
    r = m_rem - 1;
    m_rem = r;
    if (r == 0) begin
      m_done = 1; m_vel = m_lo; m_acc = 0;
    end else if (r <= m_acc) begin
      m_vel = (m_vel - m_d < m_lo) ? m_lo : m_vel - m_d;
      m_acc--;
    end else if (m_vel < m_hi && r > m_acc + 1) begin
      m_vel = (m_vel + m_d > m_hi) ? m_hi : m_vel + m_d;
      m_acc++;
    end
  endtask

  task automatic push(string tag);
    exp_t e;
    e.v = m_vel; e.d = m_done; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic go(int lo, int hi, int d, int n, bit with_step, string tag);
    @(negedge clk);
    vmin = 16'(lo); vmax = 16'(hi); accel = 16'(d); steps = 16'(n);
    start = 1'b1; step = with_step;
    m_lo = lo; m_hi = hi; m_d = d; m_rem = n; m_acc = 0; m_vel = lo;
    m_done = (n == 0) ? 1 : 0;
    push(tag);
  endtask

  task automatic stp(string tag);
    @(negedge clk);
    start = 1'b0; step = 1'b1;
    model_step();
    push(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  logic act_q = 1'b0;
  always @(posedge clk) act_q <= start | step;

  always @(negedge clk) begin
    exp_t e;
    if (act_q) begin
      if (sb.size() == 0) begin
        chk("R9 scoreboard underflow", 1, 0);
      end else begin
        e = sb.pop_front();
        chk({e.tag, " vel"}, int'(vel), e.v);
        chk({e.tag, " done"}, int'(done), e.d);
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    finish_run();
  end

  initial begin
    start = 0; step = 0; vmin = 0; vmax = 0; accel = 0; steps = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset vel", int'(vel), 0);
    chk("R1 reset done", int'(done), 1);
    rst_n = 1'b1;
    idle(2);

    stp("R7 strobe before any start");
    idle(2);

    // triangular profile, ceiling never reached
    go(100, 1000, 50, 10, 1'b0, "R2 start tri");
    repeat (5) stp("R3 R6 tri climb");
    idle(2);
    chk("R6 peak at midpoint", int'(vel), 300);
    repeat (4) stp("R5 R6 tri fall");
    idle(1);
    chk("R6 floor with one step left", int'(vel), 100);
    stp("R7 final strobe");
    repeat (2) stp("R7 strobe after done");
    idle(2);

    // trapezoid with back-to-back strobes
    go(100, 200, 50, 10, 1'b0, "R2 start trap");
    repeat (10) stp("R4 trap cruise");
    idle(2);

    // ceiling not a multiple of the delta
    go(100, 180, 50, 8, 1'b0, "R2 start clamp");
    repeat (2) stp("R4 clamp to ceiling");
    idle(1);
    chk("R4 ceiling reached", int'(vel), 180);
    repeat (6) stp("R5 floor clamp");
    idle(2);

    // inputs changed mid-move, then restart mid-move
    go(300, 900, 100, 12, 1'b0, "R2 start R8 move");
    repeat (3) stp("R8 before change");
    @(negedge clk);
    step = 0; vmin = 16'd7; vmax = 16'd60000; accel = 16'd999; steps = 16'd3;
    repeat (3) @(negedge clk);
    chk("R8 vel unchanged", int'(vel), m_vel);
    chk("R8 done unchanged", int'(done), m_done);
    repeat (5) stp("R8 after change");
    go(150, 400, 25, 6, 1'b0, "R2 restart mid-move");
    repeat (6) stp("R3 R5 restarted move");
    idle(2);

    // start and step together: step ignored
    go(500, 800, 100, 4, 1'b1, "R2 start with step");
    repeat (4) stp("R2 after combined start");
    idle(2);

    go(250, 900, 10, 0, 1'b0, "R2 zero steps");
    stp("R7 zero-step strobe");
    idle(2);

    go(700, 400, 60, 6, 1'b0, "R10 start inverted");
    repeat (6) stp("R10 constant floor");
    idle(2);

    // idle stability mid-move
    go(100, 1000, 20, 20, 1'b0, "R2 start idle test");
    repeat (4) stp("R9 pre idle");
    idle(6);
    chk("R9 idle vel", int'(vel), m_vel);
    chk("R9 idle done", int'(done), m_done);
    repeat (16) stp("R9 post idle");
    idle(2);

    // long move
    go(200, 15000, 3, 12000, 1'b0, "R11 start long");
    repeat (12000) stp("R11 long move");
    idle(3);
    chk("R11 long done", int'(done), 1);
    chk("R11 long vel", int'(vel), 200);
    chk("R9 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule